// File: doc/BRIEF.md
# Two-Page Slice Permission Checker

This unit decides whether a contiguous memory slice may be accessed with a given set of permission bits. A requester gives the address of the first doubleword and the address of the last doubleword of the slice, together with a required permission mask. Both addresses are multiples of 8, so the slice covers the bytes from the start address up to, but not including, the end address plus 8. A slice is never larger than one page, so it touches either one page or two consecutive pages. The unit works out the page index of each end and classifies the pair as equal, adjacent, or invalid. It then reads the permissions of each page it touches from an external permission table, one page at a time, and returns a single grant or deny.

Checking only takes place when the request is valid and the global enable is set. With the enable clear, every request is granted at once and the table is never read. Adjacency is tested on the page index split into a low 20-bit part and a high part, so a step that carries out of the low part into the high part still counts as adjacent.

Top module: `slice_perm_chk`

## Requirements
- R1: The pages checked are those of `req_start` and of `req_end` (address bits above bit 11). A slice whose last doubleword stays inside the start page needs one lookup, and a slice that crosses into the next page needs two.
- R2: With `chk_en` low, a request is answered in the first cycle after it is taken, with `rsp_grant`=1 and `rsp_err`=0, and `lk_req` stays low.
- R3: When both pages are equal, exactly one lookup is issued, for the start page, and the response follows one cycle after its answer.
- R4: When the end page is the start page plus one, two lookups are issued, the start page first and then the end page, and `rsp_grant` is the AND of both page results.
- R5: A start page whose low 20-bit part is all ones and an end page whose low part is zero and whose high part is one greater are treated as adjacent.
- R6: When checking is on and the pages are neither equal nor adjacent, or `req_end` is below `req_start`, the response comes in the first cycle after the request with `rsp_err`=1 and `rsp_grant`=0, and no lookup is issued.
- R7: `lk_req` and `lk_page` hold steady until `lk_ack` is seen with `lk_req`.
- R8: `rsp_valid` rises in the cycle after the last lookup is answered and stays high for exactly one cycle.
- R9: A request raised while lookups are in progress is ignored: it changes neither the pending result nor the lookups, and produces no later response.
- R10: After reset, `rsp_valid` and `lk_req` are low.
- R11: A page passes when every bit set in the mask is also set in its permissions (bit 0 read, bit 1 write, bit 2 execute); a zero mask always passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when the unit is idle |
| chk_en | input | 1 | Global enable for permission checking |
| req_start | input | ADDR_W | Address of the first doubleword of the slice |
| req_end | input | ADDR_W | Address of the last doubleword of the slice |
| req_mask | input | PERM_W | Required permissions: bit 0 read, bit 1 write, bit 2 execute |
| lk_req | output | 1 | Permission table lookup request |
| lk_page | output | ADDR_W-PAGE_SHIFT | Page index to look up |
| lk_ack | input | 1 | Lookup answer valid |
| lk_perm | input | PERM_W | Permissions of the looked-up page |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_grant | output | 1 | 1 = access allowed |
| rsp_err | output | 1 | Slice spans more than two pages or runs backwards |

## Verification
The bench builds the block with its defaults: 48-bit addresses, 4 KiB pages, a 36-bit page index split as 20 low and 16 high bits, and the split-limb adjacency variant. With these widths the carry from the low part into the high part is reached with addresses near 2^33, so both the true carry case and a false one (low part wrapping to zero with the high part unchanged) are driven. A table model answers each lookup with the page index's low three bits as permissions, so every mask and grant combination is reachable by choice of page, and a stall counter delays answers to exercise the hold and ignore rules.

// File: rtl/spc_pkg.sv
package spc_pkg;

   // Sequencer states
   typedef enum logic [1:0] {
      SPC_IDLE  = 2'd0,
      SPC_LK_LO = 2'd1,
      SPC_LK_HI = 2'd2
   } spc_state_e;

   // Bit meaning within a permission mask
   localparam int unsigned SPC_BIT_RD = 0;
   localparam int unsigned SPC_BIT_WR = 1;
   localparam int unsigned SPC_BIT_EX = 2;

endpackage

// File: rtl/spc_page_class.sv
module spc_page_class #(
   parameter int unsigned ADDR_W      = 48,
   parameter int unsigned PAGE_SHIFT  = 12,
   parameter int unsigned LO_W        = 20,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned PG_W       = ADDR_W - PAGE_SHIFT
) (
   input  logic [ADDR_W-1:0] first_addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic              active,
   output logic [PG_W-1:0]   first_pg,
   output logic [PG_W-1:0]   last_pg,
   output logic              two_pages,
   output logic              bad_span
);

   localparam int unsigned HI_W = PG_W - LO_W;

   logic same_pg;
   logic next_pg;
   logic backward;

   assign first_pg = first_addr[ADDR_W-1:PAGE_SHIFT];
   assign last_pg  = last_addr[ADDR_W-1:PAGE_SHIFT];
   assign same_pg  = (first_pg == last_pg);
   assign backward = (last_addr < first_addr);

   generate
      if (SPLIT_CARRY) begin : g_split
         logic [LO_W-1:0] f_lo, l_lo;
         logic [HI_W-1:0] f_hi, l_hi;
         logic            lo_full;
         logic            step_inside;
         logic            step_carry;

         assign f_lo    = first_pg[LO_W-1:0];
         assign l_lo    = last_pg[LO_W-1:0];
         assign f_hi    = first_pg[PG_W-1:LO_W];
         assign l_hi    = last_pg[PG_W-1:LO_W];
         assign lo_full = &f_lo;

         assign step_inside = !lo_full && (l_lo == f_lo + LO_W'(1)) && (l_hi == f_hi);
         assign step_carry  = lo_full && (l_lo == '0) && (l_hi == f_hi + HI_W'(1));
         assign next_pg     = step_inside | step_carry;
      end else begin : g_flat
         assign next_pg = (last_pg == first_pg + PG_W'(1));
      end
   endgenerate

   assign two_pages = active & next_pg & ~backward;
   assign bad_span  = active & (backward | ~(same_pg | next_pg));

endmodule

// File: rtl/spc_perm_match.sv
module spc_perm_match #(
   parameter int unsigned PERM_W = 3
) (
   input  logic [PERM_W-1:0] have,
   input  logic [PERM_W-1:0] need,
   output logic              pass
);

   logic [PERM_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < PERM_W; i++) begin : g_bit
         assign bit_ok[i] = ~need[i] | have[i];
      end
   endgenerate

   assign pass = &bit_ok;

endmodule

// File: rtl/spc_seq.sv
module spc_seq
   import spc_pkg::*;
#(
   parameter int unsigned PG_W   = 36,
   parameter int unsigned PERM_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              chk_en,
   input  logic [PERM_W-1:0] req_mask,
   input  logic [PG_W-1:0]   first_pg,
   input  logic [PG_W-1:0]   last_pg,
   input  logic              two_pages,
   input  logic              bad_span,
   input  logic              lk_ack,
   input  logic              page_pass,
   output logic              lk_req,
   output logic [PG_W-1:0]   lk_page,
   output logic [PERM_W-1:0] mask_q,
   output logic              idle,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_err
);

   spc_state_e      state_q;
   logic [PG_W-1:0] pg_lo_q;
   logic [PG_W-1:0] pg_hi_q;
   logic            two_q;
   logic            acc_q;

   assign idle    = (state_q == SPC_IDLE);
   assign lk_req  = (state_q == SPC_LK_LO) || (state_q == SPC_LK_HI);
   assign lk_page = (state_q == SPC_LK_HI) ? pg_hi_q : pg_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SPC_IDLE;
         pg_lo_q   <= '0;
         pg_hi_q   <= '0;
         two_q     <= 1'b0;
         acc_q     <= 1'b0;
         mask_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            SPC_IDLE: begin
               if (req_valid) begin
                  if (!chk_en) begin
                     rsp_valid <= 1'b1;
                     rsp_grant <= 1'b1;
                     rsp_err   <= 1'b0;
                  end else if (bad_span) begin
                     rsp_valid <= 1'b1;
                     rsp_grant <= 1'b0;
                     rsp_err   <= 1'b1;
                  end else begin
                     pg_lo_q <= first_pg;
                     pg_hi_q <= last_pg;
                     two_q   <= two_pages;
                     mask_q  <= req_mask;
                     state_q <= SPC_LK_LO;
                  end
               end
            end
            SPC_LK_LO: begin
               if (lk_ack) begin
                  if (two_q) begin
                     acc_q   <= page_pass;
                     state_q <= SPC_LK_HI;
                  end else begin
                     rsp_valid <= 1'b1;
                     rsp_grant <= page_pass;
                     rsp_err   <= 1'b0;
                     state_q   <= SPC_IDLE;
                  end
               end
            end
            SPC_LK_HI: begin
               if (lk_ack) begin
                  rsp_valid <= 1'b1;
                  rsp_grant <= acc_q & page_pass;
                  rsp_err   <= 1'b0;
                  state_q   <= SPC_IDLE;
               end
            end
            default: state_q <= SPC_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/slice_perm_chk.sv
module slice_perm_chk #(
   parameter int unsigned ADDR_W      = 48,
   parameter int unsigned PAGE_SHIFT  = 12,
   parameter int unsigned LO_W        = 20,
   parameter int unsigned PERM_W      = 3,
   parameter bit          SPLIT_CARRY = 1'b1,
   localparam int unsigned PG_W       = ADDR_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              chk_en,
   input  logic [ADDR_W-1:0] req_start,
   input  logic [ADDR_W-1:0] req_end,
   input  logic [PERM_W-1:0] req_mask,
   output logic              lk_req,
   output logic [PG_W-1:0]   lk_page,
   input  logic              lk_ack,
   input  logic [PERM_W-1:0] lk_perm,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_err
);

   generate
      if (PAGE_SHIFT < 3)      begin : g_bad_shift $error("PAGE_SHIFT must cover a doubleword"); end
      if (PG_W <= LO_W)        begin : g_bad_lo    $error("LO_W must leave a high page part"); end
      if (PERM_W < 1)          begin : g_bad_perm  $error("PERM_W must be at least 1"); end
   endgenerate

   logic              chk_active;
   logic [PG_W-1:0]   cls_first;
   logic [PG_W-1:0]   cls_last;
   logic              cls_two;
   logic              cls_bad;
   logic [PERM_W-1:0] mask_q;
   logic              page_pass;
   logic              seq_idle;

   assign chk_active = req_valid & chk_en;

   spc_page_class #(
      .ADDR_W      (ADDR_W),
      .PAGE_SHIFT  (PAGE_SHIFT),
      .LO_W        (LO_W),
      .SPLIT_CARRY (SPLIT_CARRY)
   ) class_i (
      .first_addr (req_start),
      .last_addr  (req_end),
      .active     (chk_active),
      .first_pg   (cls_first),
      .last_pg    (cls_last),
      .two_pages  (cls_two),
      .bad_span   (cls_bad)
   );

   spc_perm_match #(
      .PERM_W (PERM_W)
   ) match_i (
      .have (lk_perm),
      .need (mask_q),
      .pass (page_pass)
   );

   spc_seq #(
      .PG_W   (PG_W),
      .PERM_W (PERM_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .chk_en    (chk_en),
      .req_mask  (req_mask),
      .first_pg  (cls_first),
      .last_pg   (cls_last),
      .two_pages (cls_two),
      .bad_span  (cls_bad),
      .lk_ack    (lk_ack),
      .page_pass (page_pass),
      .lk_req    (lk_req),
      .lk_page   (lk_page),
      .mask_q    (mask_q),
      .idle      (seq_idle),
      .rsp_valid (rsp_valid),
      .rsp_grant (rsp_grant),
      .rsp_err   (rsp_err)
   );

endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
   parameter int unsigned PG_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            chk_en,
   input logic            idle,
   input logic            lk_req,
   input logic            lk_ack,
   input logic [PG_W-1:0] lk_page,
   input logic            rsp_valid,
   input logic            rsp_grant,
   input logic            rsp_err
);

   // R2
   bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && req_valid && !chk_en) |=> (rsp_valid && rsp_grant && !rsp_err && !lk_req));

   // R7
   lk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && !lk_ack) |=> (lk_req && $stable(lk_page)));

   // R8
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R8
   rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lk_req && lk_ack) && !lk_req) |-> rsp_valid);

   // R4
   second_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && $past(lk_req && lk_ack)) |-> (lk_page == $past(lk_page) + PG_W'(1)));

   // R6
   err_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> !rsp_grant);

   // R3
   no_rsp_mid_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> !rsp_valid);

endmodule

bind slice_perm_chk spc_chk #(.PG_W(PG_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .chk_en    (chk_en),
   .idle      (seq_idle),
   .lk_req    (lk_req),
   .lk_ack    (lk_ack),
   .lk_page   (lk_page),
   .rsp_valid (rsp_valid),
   .rsp_grant (rsp_grant),
   .rsp_err   (rsp_err)
);

// File: tb/slice_perm_chk_tb_top.sv
`timescale 1ns/1ps
module slice_perm_chk_tb_top;

   localparam int unsigned AW = 48;
   localparam int unsigned PS = 12;
   localparam int unsigned PW = AW - PS;

   typedef struct packed {
      logic [AW-1:0] s;
      logic [AW-1:0] e;
      logic [2:0]    m;
      logic          en;
      logic          g;
      logic          er;
      logic [1:0]    nlk;
      logic [2:0]    lat;
   } vec_t;

   // page permissions in the table model = low three bits of the page index
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{48'h13000,     48'h13ff8,     3'd3, 1'b1, 1'b1, 1'b0, 2'd1, 3'd1 + 3'd1}, // R3
      '{48'h13000,     48'h13ff8,     3'd4, 1'b1, 1'b0, 1'b0, 2'd1, 3'd2},        // R3 R11
      '{48'h13ff8,     48'h14000,     3'd1, 1'b1, 1'b0, 1'b0, 2'd2, 3'd3},        // R4
      '{48'h16ff8,     48'h17008,     3'd2, 1'b1, 1'b1, 1'b0, 2'd2, 3'd3},        // R4
      '{48'h1FFFFFFF8, 48'h200000000, 3'd0, 1'b1, 1'b1, 1'b0, 2'd2, 3'd3},        // R5 R11
      '{48'h1FFFFFFF8, 48'h200000000, 3'd4, 1'b1, 1'b0, 1'b0, 2'd2, 3'd3},        // R5
      '{48'h13000,     48'h15000,     3'd0, 1'b1, 1'b0, 1'b1, 2'd0, 3'd1},        // R6
      '{48'h13100,     48'h13000,     3'd0, 1'b1, 1'b0, 1'b1, 2'd0, 3'd1},        // R6
      '{48'h1FFFFFFF8, 48'h100000000, 3'd0, 1'b1, 1'b0, 1'b1, 2'd0, 3'd1},        // R6
      '{48'h13000,     48'h15000,     3'd7, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1},        // R2
      '{48'h15ff8,     48'h15ff8,     3'd5, 1'b1, 1'b1, 1'b0, 2'd1, 3'd2},        // R1
      '{48'h14ff8,     48'h15000,     3'd4, 1'b1, 1'b1, 1'b0, 2'd2, 3'd3}         // R1
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          chk_en = 1'b0;
   logic [AW-1:0] req_start = '0;
   logic [AW-1:0] req_end = '0;
   logic [2:0]    req_mask = '0;
   logic          lk_req;
   logic [PW-1:0] lk_page;
   logic          lk_ack;
   logic [2:0]    lk_perm;
   logic          rsp_valid;
   logic          rsp_grant;
   logic          rsp_err;

   int            n_chk = 0;
   int            n_bad = 0;
   int            stall_left = 0;
   int            lk_cnt = 0;
   logic [PW-1:0] lk_seen [2];

   always #2.5 clk = ~clk;

   slice_perm_chk dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .chk_en (chk_en),
      .req_start (req_start), .req_end (req_end), .req_mask (req_mask),
      .lk_req (lk_req), .lk_page (lk_page), .lk_ack (lk_ack), .lk_perm (lk_perm),
      .rsp_valid (rsp_valid), .rsp_grant (rsp_grant), .rsp_err (rsp_err)
   );

   // permission table model
   assign lk_ack  = lk_req && (stall_left == 0);
   assign lk_perm = lk_page[2:0];

   always @(posedge clk) begin
      if (lk_req && stall_left != 0) stall_left <= stall_left - 1;
      if (lk_req && lk_ack) begin
         if (lk_cnt < 2) lk_seen[lk_cnt] <= lk_page;
         lk_cnt <= lk_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [2:0] m,
                      input logic en, output logic g, output logic er, output int lat);
      @(negedge clk);
      lk_cnt    = 0;
      req_start = s; req_end = e; req_mask = m; chk_en = en; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      g  = rsp_grant;
      er = rsp_err;
      @(negedge clk);
      check(!rsp_valid, "R8 pulse", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      #(5ns * 5000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic g, er;
      int   lat;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(rsp_valid == 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
      check(lk_req == 1'b0, "R10 lk_req", 64'(lk_req), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         run(VECS[i].s, VECS[i].e, VECS[i].m, VECS[i].en, g, er, lat);
         check(g == VECS[i].g, $sformatf("R11 R3 R4 grant v%0d", i), 64'(g), 64'(VECS[i].g));
         check(er == VECS[i].er, $sformatf("R6 err v%0d", i), 64'(er), 64'(VECS[i].er));
         check(lk_cnt == int'(VECS[i].nlk), $sformatf("R1 R2 lookups v%0d", i), 64'(lk_cnt), 64'(VECS[i].nlk));
         check(lat == int'(VECS[i].lat), $sformatf("R8 latency v%0d", i), 64'(lat), 64'(VECS[i].lat));
         if (VECS[i].nlk >= 1)
            check(lk_seen[0] == VECS[i].s[AW-1:PS], $sformatf("R1 first page v%0d", i),
                  64'(lk_seen[0]), 64'(VECS[i].s[AW-1:PS]));
         if (VECS[i].nlk == 2)
            check(lk_seen[1] == VECS[i].e[AW-1:PS], $sformatf("R4 second page v%0d", i),
                  64'(lk_seen[1]), 64'(VECS[i].e[AW-1:PS]));
      end

      // R7 stalled first lookup: answer held back three cycles
      stall_left = 3;
      run(48'h13000, 48'h13ff8, 3'd3, 1'b1, g, er, lat);
      check(lat == 5, "R7 stalled latency", 64'(lat), 64'd5);
      check(g == 1'b1, "R7 stalled grant", 64'(g), 64'd1);
      check(lk_cnt == 1, "R7 stalled lookups", 64'(lk_cnt), 64'd1);

      // R9 request raised mid-lookup is ignored
      @(negedge clk);
      lk_cnt = 0;
      stall_left = 2;
      req_start = 48'h16ff8; req_end = 48'h17008; req_mask = 3'd2; chk_en = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_start = 48'h13000; req_end = 48'h15000; req_mask = 3'd7; chk_en = 1'b1;
      lat = 1;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 2;
      while (!rsp_valid && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      check(rsp_err == 1'b0, "R9 err", 64'(rsp_err), 64'd0);
      check(rsp_grant == 1'b1, "R9 grant", 64'(rsp_grant), 64'd1);
      check(lat == 5, "R9 latency", 64'(lat), 64'd5);
      check(lk_cnt == 2, "R9 lookups", 64'(lk_cnt), 64'd2);
      check(lk_seen[1] == PW'(36'h17), "R9 second page", 64'(lk_seen[1]), 64'h17);
      begin
         int extra = 0;
         repeat (4) begin
            @(negedge clk);
            if (rsp_valid || lk_req) extra++;
         end
         check(extra == 0, "R9 no later response", 64'(extra), 64'd0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule